// File: doc/BRIEF.md
# Spare-Row Repair Decoder

This block sits between a memory client and a storage array that has more physical rows than its rated size. Behind the rated rows sit a few spare rows. A small repair table plays the part of fuse links. Each slot of the table names one defective rated row and the spare row that stands in for it. Every access row is compared against all programmed slots at the same time. A hit sends the access to the chosen spare row. A miss sends it to the rated row unchanged. The client therefore sees a flawless array with a flat address space, and the number of spares never shows in its address.

Slots are written once through a configuration port. Writing a slot arms its lock, and any later write to that slot is dropped, the way a blown fuse cannot be blown again. The physical row is registered, so an access reaches the array exactly one cycle after it is presented. Reads and writes take the same route.

Top module: `spare_row_remap`

## Requirements
- R1: While reset is held and after it is released, every table slot is empty and `mem_valid` is 0; an access with an empty table reaches physical row equal to `req_row`.
- R2: `mem_valid`, `mem_write` and `mem_row` are registered: they show the access presented on the previous rising edge, and `mem_valid` is 0 in a cycle that follows an edge with `req_valid` low.
- R3: An access whose row equals the row stored in a programmed slot goes to physical row `ROW_CNT + spare`, where `spare` is that slot's spare index (0 to `SPARE_CNT-1`).
- R4: An access whose row matches no programmed slot goes to physical row equal to `req_row`, a value below `ROW_CNT`.
- R5: When several programmed slots hold the same row, the slot with the lowest number chooses the spare.
- R6: A write to a slot that is already programmed is ignored: that slot keeps its row and spare, and a row named only by the dropped write stays unremapped.
- R7: The write flag travels with the access unchanged, and a read and a write to the same row reach the same physical row.
- R8: With the defective rated rows repaired, data written to every rated row through the block reads back intact, although the repaired rows hold stuck bits.
- R9: A slot write takes effect from the following edge on: an access presented in the same cycle as the slot write still uses the table as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; empties the table |
| cfg_we | input | 1 | Program one repair slot this cycle |
| cfg_slot | input | SLOT_W | Slot number to program |
| cfg_row | input | ROW_W | Defective rated row that the slot replaces |
| cfg_spare | input | SPARE_W | Spare index assigned to the slot |
| req_valid | input | 1 | Access present this cycle |
| req_write | input | 1 | Access is a write (1) or a read (0) |
| req_row | input | ROW_W | Rated row of the access |
| mem_valid | output | 1 | Registered access strobe to the array |
| mem_write | output | 1 | Registered write flag to the array |
| mem_row | output | PHYS_W | Registered physical row, rated or spare |

## Verification
The assertions assume that the configuration port only ever names a spare index below `SPARE_CNT`. They also assume that the client only names rated rows, so the physical row can stay within the array. The stimulus holds to both: it programs spares 0 to 2 of a three-spare build and sweeps only rows 0 to 11 of a twelve-row build. Slot numbers above the last slot are never driven. Requests stay low during reset, so the latency check never compares against a value that was seen in reset.

// File: rtl/rrx_pkg.sv
package rrx_pkg;

    // Routing decision for one access
    typedef enum logic {
        ROUTE_PASS  = 1'b0,
        ROUTE_SPARE = 1'b1
    } route_e;

    // Index width for a count, never below one bit
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rrx_table.sv
module rrx_table #(
    parameter int SLOT_CNT  = 5,
    parameter int SPARE_CNT = 3,
    parameter int ROW_W     = 4,
    parameter int SPARE_W   = 2,
    parameter int SLOT_W    = 3
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              cfg_we,
    input  logic [SLOT_W-1:0]                 cfg_slot,
    input  logic [ROW_W-1:0]                  cfg_row,
    input  logic [SPARE_W-1:0]                cfg_spare,
    output logic [SLOT_CNT-1:0]               ent_valid,
    output logic [SLOT_CNT-1:0][ROW_W-1:0]    ent_row,
    output logic [SLOT_CNT-1:0][SPARE_W-1:0]  ent_spare
);

    typedef struct packed {
        logic               valid;
        logic               lock;
        logic [ROW_W-1:0]   row;
        logic [SPARE_W-1:0] spare;
    } slot_t;

    slot_t slot_q [SLOT_CNT];

    AST_CFG_SPARE_OK: assert property (@(posedge clk) disable iff (rst)
        cfg_we |-> (int'(cfg_spare) < SPARE_CNT)) else $error("spare index out of range"); // R3

    for (genvar g = 0; g < SLOT_CNT; g++) begin : g_slot
        logic take;
        assign take = cfg_we && (cfg_slot == SLOT_W'(g)) && !slot_q[g].lock;

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[g] <= '0;
            end else if (take) begin
                slot_q[g].valid <= 1'b1;
                slot_q[g].lock  <= 1'b1;
                slot_q[g].row   <= cfg_row;
                slot_q[g].spare <= cfg_spare;
            end
        end

        assign ent_valid[g] = slot_q[g].valid;
        assign ent_row[g]   = slot_q[g].row;
        assign ent_spare[g] = slot_q[g].spare;

        AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
            slot_q[g].lock |=> (slot_q[g].valid && $stable(slot_q[g].row)
                                && $stable(slot_q[g].spare))) else $error("locked slot changed"); // R6
    end

endmodule

// File: rtl/rrx_match.sv
module rrx_match
    import rrx_pkg::*;
#(
    parameter int SLOT_CNT = 5,
    parameter int ROW_W    = 4,
    parameter int SPARE_W  = 2,
    parameter int SLOT_W   = 3
) (
    input  logic                              rst,
    input  logic [SLOT_CNT-1:0]               ent_valid,
    input  logic [SLOT_CNT-1:0][ROW_W-1:0]    ent_row,
    input  logic [SLOT_CNT-1:0][SPARE_W-1:0]  ent_spare,
    input  logic [ROW_W-1:0]                  req_row,
    output route_e                            route,
    output logic [SPARE_W-1:0]                spare,
    output logic [SLOT_W-1:0]                 slot
);

    logic [SLOT_CNT-1:0] hit;

    // One comparator per slot, all in parallel
    for (genvar g = 0; g < SLOT_CNT; g++) begin : g_cmp
        assign hit[g] = ent_valid[g] && (ent_row[g] == req_row);
    end

    // Scan from the top down so the lowest hit is the last to be written
    always_comb begin
        route = ROUTE_PASS;
        spare = '0;
        slot  = '0;
        for (int i = SLOT_CNT - 1; i >= 0; i--) begin
            if (hit[i]) begin
                route = ROUTE_SPARE;
                spare = ent_spare[i];
                slot  = SLOT_W'(i);
            end
        end
    end

    always_comb begin
        if (!rst && route == ROUTE_SPARE) begin
            AST_SEL_MATCHES: assert (ent_valid[slot] && ent_row[slot] == req_row)
                else $error("chosen slot does not match"); // R3
            for (int j = 0; j < SLOT_CNT; j++) begin
                if (j < int'(slot)) begin
                    AST_LOWEST_WINS: assert (!(ent_valid[j] && ent_row[j] == req_row))
                        else $error("lower slot also matches"); // R5
                end
            end
        end
    end

endmodule

// File: rtl/spare_row_remap.sv
module spare_row_remap
    import rrx_pkg::*;
#(
    parameter int ROW_CNT   = 12,
    parameter int SPARE_CNT = 3,
    parameter int SLOT_CNT  = 5,
    localparam int ROW_W    = idx_w(ROW_CNT),
    localparam int SPARE_W  = idx_w(SPARE_CNT),
    localparam int SLOT_W   = idx_w(SLOT_CNT),
    localparam int PHYS_W   = idx_w(ROW_CNT + SPARE_CNT)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [SLOT_W-1:0]  cfg_slot,
    input  logic [ROW_W-1:0]   cfg_row,
    input  logic [SPARE_W-1:0] cfg_spare,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ROW_W-1:0]   req_row,
    output logic               mem_valid,
    output logic               mem_write,
    output logic [PHYS_W-1:0]  mem_row
);

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [PHYS_W-1:0] row;
    } phys_t;

    logic [SLOT_CNT-1:0]              ent_valid;
    logic [SLOT_CNT-1:0][ROW_W-1:0]   ent_row;
    logic [SLOT_CNT-1:0][SPARE_W-1:0] ent_spare;
    route_e                           route;
    logic [SPARE_W-1:0]               hit_spare;
    logic [SLOT_W-1:0]                hit_slot;
    logic [PHYS_W-1:0]                phys_nxt;
    phys_t                            out_q;

    rrx_table #(
        .SLOT_CNT (SLOT_CNT),
        .SPARE_CNT(SPARE_CNT),
        .ROW_W    (ROW_W),
        .SPARE_W  (SPARE_W),
        .SLOT_W   (SLOT_W)
    ) u_table (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_slot (cfg_slot),
        .cfg_row  (cfg_row),
        .cfg_spare(cfg_spare),
        .ent_valid(ent_valid),
        .ent_row  (ent_row),
        .ent_spare(ent_spare)
    );

    rrx_match #(
        .SLOT_CNT(SLOT_CNT),
        .ROW_W   (ROW_W),
        .SPARE_W (SPARE_W),
        .SLOT_W  (SLOT_W)
    ) u_match (
        .rst      (rst),
        .ent_valid(ent_valid),
        .ent_row  (ent_row),
        .ent_spare(ent_spare),
        .req_row  (req_row),
        .route    (route),
        .spare    (hit_spare),
        .slot     (hit_slot)
    );

    // Spares sit directly above the rated rows
    always_comb begin
        if (route == ROUTE_SPARE)
            phys_nxt = PHYS_W'(ROW_CNT) + PHYS_W'(hit_spare);
        else
            phys_nxt = PHYS_W'(req_row);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.valid <= req_valid;
            out_q.write <= req_write;
            out_q.row   <= phys_nxt;
        end
    end

    assign mem_valid = out_q.valid;
    assign mem_write = out_q.write;
    assign mem_row   = out_q.row;

    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (mem_valid == $past(req_valid))) else $error("strobe latency"); // R2
    AST_PHYS_BOUND: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (int'(mem_row) < ROW_CNT + SPARE_CNT)) else $error("row beyond array"); // R3
    AST_PASS_SAME: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && int'(mem_row) < ROW_CNT) |-> (mem_row == PHYS_W'($past(req_row))))
        else $error("rated row altered"); // R4
    AST_DIR_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_write == $past(req_write))) else $error("write flag lost"); // R7

endmodule

// File: tb/spare_row_remap_tb.sv
`timescale 1ns/1ps
module spare_row_remap_tb;

    localparam int ROWS  = 12;
    localparam int SPS   = 3;
    localparam int SLOTS = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_slot = '0;
    logic [3:0] cfg_row = '0;
    logic [1:0] cfg_spare = '0;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic [3:0] req_row = '0;
    logic       mem_valid;
    logic       mem_write;
    logic [3:0] mem_row;

    int tests = 0;
    int fails = 0;

    // Bench copy of the repair table, kept from the requirements
    bit       b_val [SLOTS];
    int       b_row [SLOTS];
    int       b_sp  [SLOTS];
    // Behavioural array with stuck-at-one bits
    logic [7:0] mem   [ROWS + SPS];
    logic [7:0] stuck [ROWS + SPS];

    always #4 clk = ~clk;

    spare_row_remap #(.ROW_CNT(ROWS), .SPARE_CNT(SPS), .SLOT_CNT(SLOTS)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_row(cfg_row),
        .cfg_spare(cfg_spare), .req_valid(req_valid), .req_write(req_write), .req_row(req_row),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_row(mem_row)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_phys(input int row);
        for (int i = 0; i < SLOTS; i++)
            if (b_val[i] && b_row[i] == row) return ROWS + b_sp[i];
        return row;
    endfunction

    // Called at a falling edge; returns at the next falling edge
    task automatic prog(input int slot, input int row, input int sp);
        cfg_we = 1'b1; cfg_slot = 3'(slot); cfg_row = 4'(row); cfg_spare = 2'(sp);
        @(negedge clk);
        cfg_we = 1'b0;
        if (!b_val[slot]) begin
            b_val[slot] = 1'b1; b_row[slot] = row; b_sp[slot] = sp;
        end
    endtask

    task automatic access(input int row, input bit wr, input logic [7:0] wd,
                          output logic [7:0] rd, output int prow, output bit pw, output bit pv);
        req_valid = 1'b1; req_write = wr; req_row = 4'(row);
        @(negedge clk);
        pv = mem_valid; pw = mem_write; prow = int'(mem_row);
        if (pv && pw && prow < ROWS + SPS) mem[prow] = wd;
        rd = (prow < ROWS + SPS) ? (mem[prow] | stuck[prow]) : 8'hxx;
        req_valid = 1'b0;
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] rd;
        int prow;
        bit pw, pv;
        for (int i = 0; i < ROWS + SPS; i++) begin mem[i] = '0; stuck[i] = '0; end
        for (int i = 0; i < SLOTS; i++) begin b_val[i] = 0; b_row[i] = 0; b_sp[i] = 0; end
        stuck[3] = 8'h10; stuck[9] = 8'h01; stuck[11] = 8'h80;

        repeat (3) @(negedge clk);
        chk("R1", "valid in reset", int'(mem_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "valid after reset", int'(mem_valid), 0);

        // R1 / R4: empty table passes every rated row through
        for (int r = 0; r < ROWS; r++) begin
            access(r, 1'b0, 8'h00, rd, prow, pw, pv);
            chk("R1", "strobe", int'(pv), 1);
            chk("R1", "pass row", prow, r);
        end
        @(negedge clk);
        chk("R2", "idle strobe", int'(mem_valid), 0);

        // R5: slots 1 and 2 both name row 9
        prog(0, 3, 2);
        prog(1, 9, 0);
        prog(2, 9, 1);
        // R6: rewrite of locked slot 0 is dropped
        prog(0, 5, 1);
        access(5, 1'b0, 8'h00, rd, prow, pw, pv);
        chk("R6", "row 5 unmapped", prow, 5);
        access(3, 1'b0, 8'h00, rd, prow, pw, pv);
        chk("R6", "slot 0 kept", prow, ROWS + 2);
        access(9, 1'b0, 8'h00, rd, prow, pw, pv);
        chk("R5", "lowest slot spare", prow, ROWS + 0);

        // R9: slot write and access in the same cycle
        cfg_we = 1'b1; cfg_slot = 3'd3; cfg_row = 4'd11; cfg_spare = 2'd1;
        req_valid = 1'b1; req_write = 1'b0; req_row = 4'd11;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        chk("R9", "old table used", int'(mem_row), 11);
        b_val[3] = 1'b1; b_row[3] = 11; b_sp[3] = 1;
        access(11, 1'b0, 8'h00, rd, prow, pw, pv);
        chk("R9", "new entry live", prow, ROWS + 1);
        chk("R3", "spare for row 11", prow, exp_phys(11));

        // R3 / R4 / R7: reads and writes route alike over all rows
        for (int r = 0; r < ROWS; r++) begin
            int pr;
            access(r, 1'b1, 8'h00, rd, prow, pw, pv);
            chk("R7", "write flag", int'(pw), 1);
            chk((exp_phys(r) >= ROWS) ? "R3" : "R4", "write route", prow, exp_phys(r));
            pr = prow;
            access(r, 1'b0, 8'h00, rd, prow, pw, pv);
            chk("R7", "read flag", int'(pw), 0);
            chk("R7", "read equals write route", prow, pr);
        end

        // R8: two complementary patterns over every rated row
        for (int pass = 0; pass < 2; pass++) begin
            for (int r = 0; r < ROWS; r++) begin
                logic [7:0] d;
                d = 8'((r * 29 + 5) & 8'hff) ^ (pass ? 8'hff : 8'h00);
                access(r, 1'b1, d, rd, prow, pw, pv);
            end
            for (int r = 0; r < ROWS; r++) begin
                logic [7:0] d;
                d = 8'((r * 29 + 5) & 8'hff) ^ (pass ? 8'hff : 8'h00);
                access(r, 1'b0, 8'h00, rd, prow, pw, pv);
                chk("R8", "readback", int'(rd), int'(d));
            end
        end

        summary();
        $finish;
    end

endmodule